// File: doc/BRIEF.md
# Pipelined Bus Master with Error Termination

This block is the master side of a pipelined address/data bus in the AHB style. A core hands it single-beat read or write requests over a valid/ready port. The block places each request on the bus as a non-sequential, single-beat transfer. The address phase of the next request overlaps the data phase of the one still in flight, so at most one data phase is outstanding while a second address waits on the bus.

Every transfer ends with a one-cycle completion pulse on the core side. For a normal end, the pulse carries the read data. For an error end, it carries an error flag, and the undefined read data is replaced with zero. Completions come back in request order.

The error response takes two cycles. A request queued behind the failing transfer is handled according to its own abort-on-error bit:
- With the bit clear, the queued request is kept and goes onto the bus when the error finishes.
- With the bit set, the queued request is consumed without its address ever being accepted, and the core receives an "aborted" completion for it.

Top module: `pipe_bus_master`

## Requirements
- R1: While reset is held and afterwards with no request, the transfer type is IDLE (2'b00), no completion pulse is given and the write data bus is zero.
- R2: A request is driven as NONSEQ (2'b10) with burst type SINGLE (3'b000), together with its address, size and write flag. It is accepted (reqReady high) at the end of a cycle in which no data phase is outstanding or the outstanding one ends with ready high.
- R3: While a data phase waits with ready low, a pending request keeps its address on the bus and reqReady stays low.
- R4: The response is OKAY when it equals 3'b000. A data phase ending with ready high and OKAY gives a completion pulse in the following cycle, with the error flag low and the sampled read data.
- R5: Any response other than 3'b000 seen with ready high ends the transfer as an error. The completion carries the error flag high and read data forced to zero.
- R6: The first error cycle (ready low, non-OKAY response) does not end the transfer. No completion is given and no new address is accepted.
- R7: Write data appears from the cycle after the write's address is accepted and is held until ready goes high. Otherwise the write data bus is zero.
- R8: If a request's abort-on-error bit is clear, a request pending behind an error is accepted at the end of the error's final cycle.
- R9: If a request's abort-on-error bit is set, the transfer type is IDLE during every cycle that shows a non-OKAY response. The request is consumed in the error's final cycle without its address being accepted, and it gets a completion with the aborted flag set one cycle after the error's completion.
- R10: Each request yields exactly one completion, in request order, and error and aborted are never both set.
- R11: With no request pending, the transfer type is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Request consumed this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqSize | input | 3 | Transfer size code |
| reqWdata | input | DATA_W | Write data |
| reqAbortOnErr | input | 1 | Drop this request if the transfer ahead ends in error |
| cplValid | output | 1 | One-cycle completion pulse |
| cplErr | output | 1 | Completion ended with an error response |
| cplAborted | output | 1 | Request was dropped without reaching the bus |
| cplRdata | output | DATA_W | Read data (zero on error or abort) |
| busTrans | output | 2 | Transfer type: IDLE 00, NONSEQ 10 |
| busAddr | output | ADDR_W | Bus address |
| busSize | output | 3 | Bus transfer size |
| busBurst | output | 3 | Burst type, always SINGLE 000 |
| busWrite | output | 1 | Bus write flag |
| busWdata | output | DATA_W | Bus write data |
| busReady | input | 1 | Slave ready |
| busResp | input | 3 | Slave response: 000 OKAY, other values are errors |
| busRdata | input | DATA_W | Slave read data |

## Verification
Two functions can fall in the same cycle: the end of an error data phase and the fate of the request queued behind it. In that cycle the block either accepts the next address or consumes the request as aborted. The bench provokes this with a slave model that inserts zero to two wait states and then answers OKAY, ERROR or another non-OKAY code on the first of three back-to-back requests, with the queued request's abort bit both clear and set. Each cycle the bench compares the transfer type, reqReady and the completion stream with a model of its own. This confirms that an aborted address never reaches the bus and that the aborted completion lands one cycle after the error completion without colliding with the next transfer's completion.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [2:0] RESP_OKAY    = 3'b000;
  localparam logic [2:0] BURST_SINGLE = 3'b000;

  typedef struct packed {
    logic driveAddr;   // request presented on the bus this cycle
    logic takeAddr;    // address phase accepted at this edge
    logic phaseEnd;    // outstanding data phase ends at this edge
    logic endErr;      // that end carries a non-OKAY response
    logic abortQ;      // an abort was taken at the previous edge
    logic dataActive;  // a data phase is outstanding
  } ctrlStrobes_t;
endpackage

// File: rtl/pbm_control.sv
module pbm_control
  import pbm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqAbortOnErr,
  input  logic         busReady,
  input  logic [2:0]   busResp,
  output logic         reqReady,
  output logic [1:0]   busTrans,
  output ctrlStrobes_t st
);
  logic dataActive;
  logic abortQ;
  logic respErr;
  logic phaseEnd;
  logic slotFree;
  logic suppress;
  logic driveAddr;
  logic takeAddr;
  logic abortNow;

  assign respErr   = (busResp != RESP_OKAY);
  assign phaseEnd  = dataActive && busReady;
  assign slotFree  = !dataActive || busReady;
  // an abort-enabled request is withdrawn while an error response is shown
  assign suppress  = dataActive && respErr && reqAbortOnErr;
  assign driveAddr = reqValid && !suppress;
  assign takeAddr  = driveAddr && slotFree;
  assign abortNow  = reqValid && reqAbortOnErr && phaseEnd && respErr;

  assign reqReady  = takeAddr || abortNow;
  assign busTrans  = driveAddr ? TRANS_NONSEQ : TRANS_IDLE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataActive <= 1'b0;
      abortQ     <= 1'b0;
    end else begin
      if (takeAddr)      dataActive <= 1'b1;
      else if (phaseEnd) dataActive <= 1'b0;
      abortQ <= abortNow;
    end
  end

  always_comb begin
    st.driveAddr  = driveAddr;
    st.takeAddr   = takeAddr;
    st.phaseEnd   = phaseEnd;
    st.endErr     = phaseEnd && respErr;
    st.abortQ     = abortQ;
    st.dataActive = dataActive;
  end

  // R3: no request is consumed while a data phase waits
  a_r3_wait_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (dataActive && !busReady) |-> !reqReady);

  // R6: a waited data phase (including the first error cycle) stays outstanding
  a_r6_err_first_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dataActive && !busReady) |=> dataActive);

  // R9: the aborted request was never on the bus in its consuming cycle
  a_r9_abort_no_addr: assert property (@(posedge clk) disable iff (!rstN)
    abortQ |-> ($past(busTrans) == TRANS_IDLE));
endmodule

// File: rtl/pbm_datapath.sv
module pbm_datapath
  import pbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      st,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busSize,
  output logic [2:0]        busBurst,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic              cplValid,
  output logic              cplErr,
  output logic              cplAborted,
  output logic [DATA_W-1:0] cplRdata
);
  logic              dpWrite;
  logic [DATA_W-1:0] dpWdata;

  // address-phase signals follow the request while it is presented
  always_comb begin
    busAddr  = st.driveAddr ? reqAddr  : '0;
    busSize  = st.driveAddr ? reqSize  : '0;
    busWrite = st.driveAddr ? reqWrite : 1'b0;
    busBurst = BURST_SINGLE;
  end

  // data-phase register: captured when the address is accepted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpWrite <= 1'b0;
      dpWdata <= '0;
    end else if (st.takeAddr) begin
      dpWrite <= reqWrite;
      dpWdata <= reqWrite ? reqWdata : '0;
    end
  end

  assign busWdata = (st.dataActive && dpWrite) ? dpWdata : '0;

  // completion register: a data-phase end has precedence, abort follows a cycle later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cplValid   <= 1'b0;
      cplErr     <= 1'b0;
      cplAborted <= 1'b0;
      cplRdata   <= '0;
    end else if (st.phaseEnd) begin
      cplValid   <= 1'b1;
      cplErr     <= st.endErr;
      cplAborted <= 1'b0;
      cplRdata   <= (st.endErr || dpWrite) ? '0 : busRdata;
    end else if (st.abortQ) begin
      cplValid   <= 1'b1;
      cplErr     <= 1'b0;
      cplAborted <= 1'b1;
      cplRdata   <= '0;
    end else begin
      cplValid   <= 1'b0;
      cplErr     <= 1'b0;
      cplAborted <= 1'b0;
      cplRdata   <= '0;
    end
  end

  // R7: write data does not move while the data phase waits
  a_r7_wdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    (st.dataActive && !st.phaseEnd) |=> $stable(busWdata));

  // R5: error completions never expose read data
  a_r5_err_data_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && cplErr) |-> (cplRdata == '0));

  // R10: error and aborted are exclusive
  a_r10_kind_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cplErr, cplAborted}));

  // R4: every completion has a cause at the previous edge
  a_r4_cpl_cause: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |-> $past(st.phaseEnd || st.abortQ));
endmodule

// File: rtl/pipe_bus_master.sv
module pipe_bus_master
  import pbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqAbortOnErr,
  output logic              cplValid,
  output logic              cplErr,
  output logic              cplAborted,
  output logic [DATA_W-1:0] cplRdata,
  output logic [1:0]        busTrans,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busSize,
  output logic [2:0]        busBurst,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busReady,
  input  logic [2:0]        busResp,
  input  logic [DATA_W-1:0] busRdata
);
  ctrlStrobes_t st;

  pbm_control u_control (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqAbortOnErr (reqAbortOnErr),
    .busReady      (busReady),
    .busResp       (busResp),
    .reqReady      (reqReady),
    .busTrans      (busTrans),
    .st            (st)
  );

  pbm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWdata   (reqWdata),
    .busRdata   (busRdata),
    .busAddr    (busAddr),
    .busSize    (busSize),
    .busBurst   (busBurst),
    .busWrite   (busWrite),
    .busWdata   (busWdata),
    .cplValid   (cplValid),
    .cplErr     (cplErr),
    .cplAborted (cplAborted),
    .cplRdata   (cplRdata)
  );
endmodule

// File: tb/test_pipe_bus_master.sv
module test_pipe_bus_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        reqAbortOnErr = 1'b0;
  logic        cplValid, cplErr, cplAborted;
  logic [31:0] cplRdata;
  logic [1:0]  busTrans;
  logic [31:0] busAddr;
  logic [2:0]  busSize, busBurst;
  logic        busWrite;
  logic [31:0] busWdata;
  logic        busReady = 1'b1;
  logic [2:0]  busResp = 3'b000;
  logic [31:0] busRdata = '0;

  always #2 clk = ~clk;  // 250 MHz

  pipe_bus_master i_pipe_bus_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .reqAbortOnErr(reqAbortOnErr), .cplValid(cplValid), .cplErr(cplErr),
    .cplAborted(cplAborted), .cplRdata(cplRdata), .busTrans(busTrans),
    .busAddr(busAddr), .busSize(busSize), .busBurst(busBurst), .busWrite(busWrite),
    .busWdata(busWdata), .busReady(busReady), .busResp(busResp), .busRdata(busRdata)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdFor(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  // core-side request queue
  logic [31:0] qAddr [3];
  logic [31:0] qWdata[3];
  bit          qWr   [3];
  bit          qAe   [3];
  int          head;

  // slave model
  bit          sActive;
  int          sCnt;
  logic [31:0] sAddr, sWdata;
  bit          sWr, sErrPhase;
  int          waitN;
  logic [2:0]  errCode;

  // expected completion pipeline
  bit          e1V, e1Err, e1Ab, abortFlag;
  logic [31:0] e1Data;
  int          cplCount;

  task automatic runCycle();
    bit rdyNow, phaseEnd, errEnd, supExp, rrExp, acc, abt, vNow;
    logic [2:0] respNow;
    logic [1:0] trExp;
    logic [31:0] wdExp;
    @(negedge clk);
    vNow = (head < 3);
    reqValid      = vNow;
    reqWrite      = vNow ? qWr[head]    : 1'b0;
    reqAddr       = vNow ? qAddr[head]  : '0;
    reqWdata      = vNow ? qWdata[head] : '0;
    reqSize       = vNow ? 3'b010       : 3'b000;
    reqAbortOnErr = vNow ? qAe[head]    : 1'b0;
    if (!sActive) begin
      rdyNow = 1'b1; respNow = 3'b000;
    end else if (!sErrPhase) begin
      rdyNow = (sCnt >= waitN); respNow = 3'b000;
    end else begin
      rdyNow = (sCnt >= waitN + 1);
      respNow = (sCnt >= waitN) ? errCode : 3'b000;
    end
    busReady = rdyNow;
    busResp  = respNow;
    busRdata = (sActive && rdyNow && respNow == 3'b000) ? rdFor(sAddr) : 32'hDEAD_BEEF;
    #1;
    supExp = sActive && (respNow != 3'b000) && vNow && qAe[head];
    rrExp  = vNow && ((((!sActive) || rdyNow) && !supExp) ||
                      (sActive && rdyNow && (respNow != 3'b000) && qAe[head]));
    if (sActive && !rdyNow)
      chk(reqReady == rrExp, "R3/R6", "reqReady while waiting", reqReady, rrExp);
    else if (supExp)
      chk(reqReady == rrExp, "R9", "reqReady abort", reqReady, rrExp);
    else if (sActive && respNow != 3'b000)
      chk(reqReady == rrExp, "R8", "reqReady keep after error", reqReady, rrExp);
    else
      chk(reqReady == rrExp, "R2", "reqReady", reqReady, rrExp);
    trExp = (vNow && !supExp) ? 2'b10 : 2'b00;
    if (!vNow)       chk(busTrans == trExp, "R11", "trans idle", busTrans, trExp);
    else if (supExp) chk(busTrans == trExp, "R9", "trans withdrawn", busTrans, trExp);
    else begin
      chk(busTrans == trExp, "R2", "trans nonseq", busTrans, trExp);
      chk(busAddr == qAddr[head], "R3", "address held", busAddr, qAddr[head]);
      chk(busWrite == qWr[head] && busSize == 3'b010 && busBurst == 3'b000, "R2",
          "write/size/burst", {busWrite, busSize, busBurst}, {qWr[head], 3'b010, 3'b000});
    end
    wdExp = (sActive && sWr) ? sWdata : '0;
    chk(busWdata == wdExp, "R7", "write data", busWdata, wdExp);
    if (cplValid || e1V) begin
      chk(cplValid == e1V, "R10", "completion presence", cplValid, e1V);
      if (e1Ab)
        chk(cplAborted && !cplErr && cplRdata == '0, "R9", "aborted completion",
            {cplAborted, cplErr, cplRdata}, {1'b1, 1'b0, 32'h0});
      else if (e1Err)
        chk(cplErr && !cplAborted && cplRdata == '0, "R5", "error completion",
            {cplAborted, cplErr, cplRdata}, {1'b0, 1'b1, 32'h0});
      else
        chk(!cplErr && !cplAborted && cplRdata == e1Data, "R4", "okay completion",
            {cplAborted, cplErr, cplRdata}, {2'b00, e1Data});
    end
    if (cplValid) cplCount++;
    // model update for the coming edge
    phaseEnd = sActive && rdyNow;
    errEnd   = phaseEnd && (respNow != 3'b000);
    if (phaseEnd) begin
      e1V = 1'b1; e1Err = errEnd; e1Ab = 1'b0;
      e1Data = (errEnd || sWr) ? 32'h0 : rdFor(sAddr);
    end else if (abortFlag) begin
      e1V = 1'b1; e1Err = 1'b0; e1Ab = 1'b1; e1Data = '0; abortFlag = 1'b0;
    end else begin
      e1V = 1'b0; e1Err = 1'b0; e1Ab = 1'b0; e1Data = '0;
    end
    acc = vNow && !supExp && ((!sActive) || rdyNow);
    abt = vNow && sActive && rdyNow && (respNow != 3'b000) && qAe[head];
    if (abt) abortFlag = 1'b1;
    if (acc) begin
      sActive = 1'b1; sCnt = 0; sAddr = qAddr[head]; sWr = qWr[head];
      sWdata = qWdata[head]; sErrPhase = (head == 0) && (errCode != 3'b000);
      head++;
    end else if (abt) begin
      head++; sActive = 1'b0;
    end else if (phaseEnd) begin
      sActive = 1'b0;
    end else if (sActive) begin
      sCnt++;
    end
  endtask

  initial begin
    int scen;
    head = 3; sActive = 0; sCnt = 0; e1V = 0; e1Err = 0; e1Ab = 0; abortFlag = 0;
    e1Data = '0; sAddr = '0; sWdata = '0; sWr = 0; sErrPhase = 0; waitN = 0;
    errCode = 3'b000; cplCount = 0;
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(busTrans == 2'b00 && !cplValid && busWdata == '0, "R1", "reset state",
          {busTrans, cplValid, busWdata}, 35'h0);
    end
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 2; i++) begin
      runCycle();
      chk(!cplValid, "R1", "idle after reset", cplValid, 0);
    end
    scen = 0;
    for (int w = 0; w < 3; w++)
      for (int c = 0; c < 3; c++)
        for (int wr = 0; wr < 2; wr++)
          for (int ae = 0; ae < 2; ae++) begin
            int cyc;
            waitN   = w;
            errCode = (c == 0) ? 3'b000 : ((c == 1) ? 3'b001 : 3'b110);
            for (int k = 0; k < 3; k++) begin
              qAddr[k]  = 32'h1000_0000 + scen * 32'h40 + k * 4;
              qWdata[k] = (qAddr[k] * 3) ^ 32'hC3C3_1234;
            end
            qWr[0] = wr[0]; qWr[1] = 1'b0; qWr[2] = 1'b1;
            qAe[0] = 1'b0;  qAe[1] = ae[0]; qAe[2] = ae[0];
            head = 0; cplCount = 0; cyc = 0;
            while (cyc < 80 && !(head == 3 && !sActive && !e1V && !abortFlag && cplCount == 3)) begin
              runCycle();
              cyc++;
            end
            if (cyc >= 80) chk(1'b0, "R10", "scenario watchdog", cyc, 80);
            chk(cplCount == 3, "R10", "one completion per request", cplCount, 3);
            scen++;
          end
    for (int i = 0; i < 3; i++) runCycle();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule